// File: doc/BRIEF.md
# Scrypt ROMix Mixing Core with Lookup Gap

This core performs the sequential memory-hard mixing step of the scrypt proof-of-work function for one lane. The cost is N = 1024 and the block size is r = 1. A 1024-bit working block arrives on a valid/ready input port. The core runs two phases and then presents the mixed 1024-bit block on a valid/ready output port.

In the fill phase, the core applies BlockMix to the state N times and saves snapshots of the state into an internal synchronous RAM. In the mix phase, the core performs N iterations. Each iteration picks a data-dependent index, fetches the matching snapshot, XORs it into the state and applies BlockMix again.

A lookup gap G (1, 2, 4 or 8) keeps only every G-th snapshot. This cuts the RAM to N/G rows of 1024 bits. A missing snapshot is rebuilt on demand by applying BlockMix to the nearest stored row below it.

The core holds one job at a time. It takes no new block until the previous result has been collected.

Top module: `romix_core`

## Requirements
- R1: `in_ready` is high only while the core holds no job. A block is taken on a clock edge where `in_valid` and `in_ready` are both high. While a job is running, or while a result waits to be collected, `in_ready` stays low and `in_valid`/`in_data` have no effect.
- R2: The result equals scrypt ROMix of the input with N = 1024 and r = 1. A block is 32 little-endian 32-bit words, with word k at bits [32k+31:32k]. Half B0 is words 0..15 and half B1 is words 16..31.
- R3: BlockMix computes Y0 = Salsa(B1 xor B0), then Y1 = Salsa(Y0 xor B1). The new block has Y0 as words 0..15 and Y1 as words 16..31.
- R4: Salsa20/8 runs 8 rounds that alternate between column rounds and row rounds, starting with a column round. It then adds the round input to the result word by word, modulo 2^32.
- R5: In the mix phase, the snapshot index j is word 16 of the current state, taken modulo 1024.
- R6: The RAM holds N/G rows, and row m holds the state after m*G BlockMix steps. For index j, the core reads row floor(j/G) and applies BlockMix (j mod G) times. The result is the same as for a full scratchpad, for every G in {1, 2, 4, 8}.
- R7: Once `out_valid` rises, it stays high and `out_data` holds its value until the edge where `out_ready` is high. One cycle after that edge, `out_valid` is low.
- R8: While reset is asserted and right after it is released, `in_ready` is 1 and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the core |
| in_valid | input | 1 | Input block offered |
| in_ready | output | 1 | Core is idle and will take a block |
| in_data | input | 1024 | Input block, 32 little-endian words |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 1024 | Mixed result block |

## Verification
Most wrong internal states cannot be seen until the job ends. A bad round count, a wrong index bit, a wrong recompute count or a bad RAM row goes through more than a thousand data-dependent mixing steps, so it shows up only as a wrong `out_data` when `out_valid` rises. For this reason the result of each job is compared against a gapless behavioural ROMix model. Handshake faults are visible at once: a leaked acceptance or a released output shows on `in_ready` or `out_valid` within one cycle, and the bench compares both against its model on every clock. An input that skips the recompute path entirely (the all-zero block, whose index is always 0) is run next to one that exercises it.

// File: rtl/romix_pkg.sv
package romix_pkg;

  typedef logic [511:0]  half_t;
  typedef logic [1023:0] blk_t;

  function automatic logic [31:0] rotl32(input logic [31:0] v, input int n);
    return (v << n) | (v >> (32 - n));
  endfunction

  // one Salsa round; row=0 column round, row=1 row round
  function automatic half_t salsa_round(input half_t s, input logic row);
    logic [31:0] w [16];
    half_t       r;
    int          a, b, c, d;
    for (int i = 0; i < 16; i++) w[i] = s[32*i +: 32];
    for (int g = 0; g < 4; g++) begin
      a = 5 * g;
      if (row) begin
        b = 4 * g + (g + 1) % 4;
        c = 4 * g + (g + 2) % 4;
        d = 4 * g + (g + 3) % 4;
      end else begin
        b = (a + 4) % 16;
        c = (a + 8) % 16;
        d = (a + 12) % 16;
      end
      w[b] = w[b] ^ rotl32(w[a] + w[d], 7);
      w[c] = w[c] ^ rotl32(w[b] + w[a], 9);
      w[d] = w[d] ^ rotl32(w[c] + w[b], 13);
      w[a] = w[a] ^ rotl32(w[d] + w[c], 18);
    end
    for (int i = 0; i < 16; i++) r[32*i +: 32] = w[i];
    return r;
  endfunction

  function automatic half_t word_add(input half_t p, input half_t q);
    half_t r;
    for (int i = 0; i < 16; i++) r[32*i +: 32] = p[32*i +: 32] + q[32*i +: 32];
    return r;
  endfunction

endpackage

// File: rtl/romix_salsa.sv
module romix_salsa
  import romix_pkg::*;
#(
  parameter int ROUNDS = 8
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  half_t din,
  output logic  busy,
  output logic  done,
  output half_t dout
);
  localparam int CW = $clog2(ROUNDS);

  half_t         work_q, work_d, save_q, save_d, dout_q, dout_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          run_q, run_d, ff_q, ff_d, done_q, done_d;

  always_comb begin
    work_d = work_q;
    save_d = save_q;
    dout_d = dout_q;
    cnt_d  = cnt_q;
    run_d  = run_q;
    ff_d   = ff_q;
    done_d = 1'b0;
    if (start) begin
      work_d = din;
      save_d = din;
      cnt_d  = '0;
      run_d  = 1'b1;
    end else if (run_q) begin
      work_d = salsa_round(work_q, cnt_q[0]);
      cnt_d  = cnt_q + CW'(1);
      if (cnt_q == CW'(ROUNDS - 1)) begin
        run_d = 1'b0;
        ff_d  = 1'b1;
      end
    end else if (ff_q) begin
      dout_d = word_add(work_q, save_q);
      done_d = 1'b1;
      ff_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      ff_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      run_q  <= run_d;
      ff_q   <= ff_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk) begin
    work_q <= work_d;
    save_q <= save_d;
    dout_q <= dout_d;
  end

  assign busy = run_q | ff_q;
  assign done = done_q;
  assign dout = dout_q;

  AST_SALSA_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy); // R4
  AST_SALSA_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R4
endmodule

// File: rtl/romix_blockmix.sv
module romix_blockmix
  import romix_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  blk_t din,
  output logic busy,
  output logic done,
  output blk_t dout
);
  typedef enum logic [1:0] {BM_IDLE, BM_FIRST, BM_SECOND} bm_st_t;

  bm_st_t st_q, st_d;
  half_t  b1_q, b1_d, y0_q, y0_d;
  blk_t   dout_q, dout_d;
  logic   done_q, done_d;
  logic   s_start, s_busy, s_done;
  half_t  s_in, s_out;

  assign s_start = (st_q == BM_IDLE && start) || (st_q == BM_FIRST && s_done);
  assign s_in    = (st_q == BM_IDLE) ? (din[1023:512] ^ din[511:0]) : (s_out ^ b1_q);

  romix_salsa #(.ROUNDS(8)) u_salsa (
    .clk(clk), .rst_n(rst_n), .start(s_start), .din(s_in),
    .busy(s_busy), .done(s_done), .dout(s_out)
  );

  always_comb begin
    st_d   = st_q;
    b1_d   = b1_q;
    y0_d   = y0_q;
    dout_d = dout_q;
    done_d = 1'b0;
    unique case (st_q)
      BM_IDLE: if (start) begin
        b1_d = din[1023:512];
        st_d = BM_FIRST;
      end
      BM_FIRST: if (s_done) begin
        y0_d = s_out;
        st_d = BM_SECOND;
      end
      BM_SECOND: if (s_done) begin
        dout_d = {s_out, y0_q};
        done_d = 1'b1;
        st_d   = BM_IDLE;
      end
      default: st_d = BM_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= BM_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk) begin
    b1_q   <= b1_d;
    y0_q   <= y0_d;
    dout_q <= dout_d;
  end

  assign busy = (st_q != BM_IDLE);
  assign done = done_q;
  assign dout = dout_q;

  AST_BM_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (st_q == BM_IDLE) && !s_busy); // R3
endmodule

// File: rtl/romix_spad.sv
module romix_spad #(
  parameter int DEPTH = 512,
  parameter int AW    = 9,
  parameter int W     = 1024
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/romix_core.sv
module romix_core
  import romix_pkg::*;
#(
  parameter int COST = 1024,
  parameter int GAP  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [1023:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [1023:0] out_data
);
  localparam int IW    = $clog2(COST);
  localparam int DEPTH = COST / GAP;
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int KW    = $clog2(GAP) + 1;

  typedef enum logic [3:0] {
    S_IDLE, S_FILL, S_FILL_WAIT, S_RD, S_FETCH, S_CHAIN, S_RECOMP, S_MIX, S_MIX_WAIT, S_DONE
  } st_t;

  logic rst_q1, rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1 <= 1'b0;
      rst_i  <= 1'b0;
    end else begin
      rst_q1 <= 1'b1;
      rst_i  <= rst_q1;
    end
  end

  st_t           st_q, st_d;
  blk_t          x_q, x_d, t_q, t_d;
  logic [IW-1:0] idx_q, idx_d, j;
  logic [KW-1:0] k_q, k_d;
  logic          bm_start, bm_busy, bm_done, we, re;
  blk_t          bm_in, bm_out, rdata;
  logic [AW-1:0] waddr, raddr;

  assign j     = x_q[512 +: IW];
  assign raddr = AW'(int'(j) / GAP);
  assign waddr = AW'(int'(idx_q) / GAP);
  assign we    = (st_q == S_FILL) && ((int'(idx_q) % GAP) == 0);
  assign re    = (st_q == S_RD);

  romix_spad #(.DEPTH(DEPTH), .AW(AW), .W(1024)) u_spad (
    .clk(clk), .we(we), .waddr(waddr), .wdata(x_q),
    .re(re), .raddr(raddr), .rdata(rdata)
  );

  romix_blockmix u_bm (
    .clk(clk), .rst_n(rst_i), .start(bm_start), .din(bm_in),
    .busy(bm_busy), .done(bm_done), .dout(bm_out)
  );

  always_comb begin
    st_d     = st_q;
    x_d      = x_q;
    t_d      = t_q;
    idx_d    = idx_q;
    k_d      = k_q;
    bm_start = 1'b0;
    bm_in    = x_q;
    unique case (st_q)
      S_IDLE: if (in_valid) begin
        x_d   = in_data;
        idx_d = '0;
        st_d  = S_FILL;
      end
      S_FILL: begin
        bm_start = 1'b1;
        st_d     = S_FILL_WAIT;
      end
      S_FILL_WAIT: if (bm_done) begin
        x_d   = bm_out;
        idx_d = idx_q + IW'(1);
        st_d  = (idx_q == IW'(COST - 1)) ? S_RD : S_FILL;
      end
      S_RD: begin
        k_d  = KW'(int'(j) % GAP);
        st_d = S_FETCH;
      end
      S_FETCH: begin
        t_d  = rdata;
        st_d = S_CHAIN;
      end
      S_CHAIN: begin
        if (k_q == '0) begin
          st_d = S_MIX;
        end else begin
          bm_start = 1'b1;
          bm_in    = t_q;
          st_d     = S_RECOMP;
        end
      end
      S_RECOMP: if (bm_done) begin
        t_d  = bm_out;
        k_d  = k_q - KW'(1);
        st_d = S_CHAIN;
      end
      S_MIX: begin
        bm_start = 1'b1;
        bm_in    = x_q ^ t_q;
        st_d     = S_MIX_WAIT;
      end
      S_MIX_WAIT: if (bm_done) begin
        x_d   = bm_out;
        idx_d = idx_q + IW'(1);
        st_d  = (idx_q == IW'(COST - 1)) ? S_DONE : S_RD;
      end
      S_DONE: if (out_ready) st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      st_q  <= S_IDLE;
      idx_q <= '0;
      k_q   <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      k_q   <= k_d;
    end
  end

  always_ff @(posedge clk) begin
    x_q <= x_d;
    t_q <= t_d;
  end

  assign in_ready  = (st_q == S_IDLE);
  assign out_valid = (st_q == S_DONE);
  assign out_data  = x_q;

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_i)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R7
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_i)
    in_valid && in_ready |=> !in_ready && !out_valid); // R1
  AST_READ_WHILE_BM_IDLE: assert property (@(posedge clk) disable iff (!rst_i)
    re |-> !bm_busy); // R6
endmodule

// File: tb/romix_core_bench.sv
module romix_core_bench;
  logic          clk = 1'b0;
  logic          rst_n, in_valid, in_ready, out_valid, out_ready;
  logic [1023:0] in_data, out_data;

  always #5 clk = ~clk;

  romix_core u_romix_core (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  int checks = 0, failures = 0, cyc = 0;
  int acc_cnt = 0, out_cnt = 0;
  logic          model_on = 1'b0, exp_ready = 1'b1, holding = 1'b0;
  logic [1023:0] held;
  logic [1023:0] exp_q [$];
  logic [1023:0] vref [1024];

  task automatic chk(input logic ok, input string req, input logic [1023:0] act,
                     input logic [1023:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void qr(ref bit [31:0] w[16], input int a, input int b,
                             input int c, input int d);
    w[b] ^= (((w[a] + w[d]) << 7)  | ((w[a] + w[d]) >> 25));
    w[c] ^= (((w[b] + w[a]) << 9)  | ((w[b] + w[a]) >> 23));
    w[d] ^= (((w[c] + w[b]) << 13) | ((w[c] + w[b]) >> 19));
    w[a] ^= (((w[d] + w[c]) << 18) | ((w[d] + w[c]) >> 14));
  endfunction

  function automatic logic [511:0] m_salsa(input logic [511:0] v);
    bit [31:0] w[16];
    bit [31:0] o[16];
    logic [511:0] r;
    for (int i = 0; i < 16; i++) begin w[i] = v[32*i +: 32]; o[i] = w[i]; end
    for (int n = 0; n < 4; n++) begin
      qr(w, 0, 4, 8, 12);  qr(w, 5, 9, 13, 1);
      qr(w, 10, 14, 2, 6); qr(w, 15, 3, 7, 11);
      qr(w, 0, 1, 2, 3);   qr(w, 5, 6, 7, 4);
      qr(w, 10, 11, 8, 9); qr(w, 15, 12, 13, 14);
    end
    for (int i = 0; i < 16; i++) r[32*i +: 32] = w[i] + o[i];
    return r;
  endfunction

  function automatic logic [1023:0] m_bmix(input logic [1023:0] b);
    logic [511:0] y0, y1;
    y0 = m_salsa(b[1023:512] ^ b[511:0]);
    y1 = m_salsa(y0 ^ b[1023:512]);
    return {y1, y0};
  endfunction

  // gapless ROMix, N=1024
  function automatic logic [1023:0] m_romix(input logic [1023:0] b);
    logic [1023:0] x;
    int jj;
    x = b;
    for (int i = 0; i < 1024; i++) begin vref[i] = x; x = m_bmix(x); end
    for (int i = 0; i < 1024; i++) begin
      jj = int'(x[512 +: 32] % 1024);
      x  = m_bmix(x ^ vref[jj]);
    end
    return x;
  endfunction

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      failures++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", cyc, 190000);
      finish_run();
    end
  end

  // cycle-by-cycle model, compared away from the active edge
  always @(negedge clk) begin
    if (model_on) begin
      chk(in_ready == exp_ready, "R1 in_ready", 1024'(in_ready), 1024'(exp_ready));
      if (exp_ready) chk(!out_valid, "R1 out_valid idle", 1024'(out_valid), 1024'(0));
      if (holding) begin
        chk(out_valid == 1'b1, "R7 out_valid held", 1024'(out_valid), 1024'(1));
        chk(out_data == held, "R7 out_data stable", out_data, held);
      end else if (out_valid) begin
        if (exp_q.size() == 0) chk(1'b0, "R1 unexpected result", out_data, '0);
        else chk(out_data == exp_q[0], "R2 R3 R4 R5 R6 result", out_data, exp_q[0]);
        holding = 1'b1;
        held    = out_data;
      end
      if (in_valid && in_ready) begin
        exp_q.push_back(m_romix(in_data));
        exp_ready = 1'b0;
        acc_cnt++;
      end
      if (out_valid && out_ready && holding) begin
        if (exp_q.size() > 0) void'(exp_q.pop_front());
        holding   = 1'b0;
        exp_ready = 1'b1;
        out_cnt++;
      end
    end
  end

  initial begin
    logic [1023:0] pat;
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1, "R8 in_ready in reset", 1024'(in_ready), 1024'(1));
    chk(out_valid == 1'b0, "R8 out_valid in reset", 1024'(out_valid), 1024'(0));
    @(posedge clk); #2 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(in_ready == 1'b1, "R8 in_ready after release", 1024'(in_ready), 1024'(1));
    chk(out_valid == 1'b0, "R8 out_valid after release", 1024'(out_valid), 1024'(0));
    model_on = 1'b1;

    for (int i = 0; i < 32; i++) pat[32*i +: 32] = 32'h9e3779b9 * (i + 1) ^ 32'h0badf00d;
    @(posedge clk); #2 in_valid = 1'b1; in_data = pat;
    while (acc_cnt < 1) @(negedge clk);
    @(posedge clk); #2 in_data = ~pat;   // R1: offered while busy, must be ignored
    repeat (200) @(posedge clk);
    #2 in_valid = 1'b0;
    @(negedge clk);
    chk(acc_cnt == 1, "R1 no accept while busy", 1024'(acc_cnt), 1024'(1));

    while (!out_valid) @(negedge clk);
    repeat (40) @(negedge clk);          // R7 hold with out_ready low
    @(posedge clk); #2 in_valid = 1'b1; in_data = '0;
    repeat (10) @(negedge clk);
    chk(acc_cnt == 1, "R1 stall until result taken", 1024'(acc_cnt), 1024'(1));
    @(posedge clk); #2 out_ready = 1'b1;
    while (out_cnt < 1) @(negedge clk);
    @(posedge clk); #2 out_ready = 1'b0;
    while (acc_cnt < 2) @(negedge clk);
    @(posedge clk); #2 in_valid = 1'b0; out_ready = 1'b1;
    while (out_cnt < 2) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(out_cnt == 2, "R2 two results", 1024'(out_cnt), 1024'(2));
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R7 released after take",
        1024'({in_ready, out_valid}), 1024'(2));
    finish_run();
  end
endmodule